// File: doc/BRIEF.md
# Alignment Direction Recorder and Traceback

This block sits beside a dynamic-programming scorer that fills an alignment grid of `ROWS` x `COLS` cells. While the scorer runs, the block takes, for each cell, a two-bit code naming the neighbour that supplied the winning score: diagonal, from above, or from the left. The codes are packed into 36-bit words in a small internal memory. Scores are never kept, because the direction codes alone are enough to rebuild the alignment.

When the last cell has been recorded, the block walks the grid backwards from the bottom-right cell to the origin. At each step it emits one alignment operation: a match, a gap in sequence B, or a gap in sequence A. The operations come out in reverse alignment order on a valid/ready stream, and the final one carries a last flag. After the last operation has been accepted, the block is ready to record the next grid.

Top module: `align_dir_trace`

## Requirements
- R1: After reset, `recReady` is 1 and `opValid` is 0.
- R2: While `recReady` is 1, each cycle with `dirValid` high records one code. Cells arrive in column-major order: cell (i,j), with 1<=i<=ROWS and 1<=j<=COLS, is number (j-1)*ROWS+(i-1). Code 00 means diagonal, 01 means up and 10 means left. Code 11 is treated as diagonal.
- R3: Eighteen codes share one 36-bit word. Cell n sits in word n/18, at bits [2*(n%18)+1 : 2*(n%18)]. A partly filled final word is still written when the last cell arrives.
- R4: The cycle after the last cell is recorded, `recReady` is 0 and the walk starts at cell (ROWS,COLS).
- R5: The operation code is 00 (match) for a diagonal step to (i-1,j-1), 01 (gap in B) for an up step to (i-1,j), and 10 (gap in A) for a left step to (i,j-1).
- R6: In row 0 the step is forced to left (10). In column 0 it is forced to up (01). The stored code is ignored in both cases.
- R7: `opLast` is 1 only on the operation that reaches (0,0). One traceback gives between max(ROWS,COLS) and ROWS+COLS operations.
- R8: While `opValid` is 1 and `opReady` is 0, `opValid`, `opCode` and `opLast` hold their values.
- R9: `dirValid` and `dirCode` have no effect while `recReady` is 0.
- R10: The cycle after the last operation is accepted, `recReady` is 1 again. The next grid is traced using only its own codes.
- R11: `opCode` is never 11 while `opValid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirValid | input | 1 | A direction code is present for the next cell |
| dirCode | input | 2 | Winning-neighbour code for the cell |
| recReady | output | 1 | Block is recording and accepts codes |
| opValid | output | 1 | An alignment operation is offered |
| opReady | input | 1 | Consumer takes the offered operation |
| opCode | output | 2 | Alignment operation (00 match, 01 gap in B, 10 gap in A) |
| opLast | output | 1 | Offered operation is the final one of the traceback |

## Verification
The assertions check on every cycle that the output stream is held stable under back-pressure and never shows the unused code. They also check that recording and emitting never overlap, that the last flag only appears on a valid operation and hands control back to recording, and that no traceback runs longer than ROWS+COLS operations. Whether each emitted operation is the right one can only be shown by the bench. It compares the stream with a walk computed from the grid it sent. That comparison covers column-major packing across word boundaries, the partial final word, the forced moves along row 0 and column 0, code 11, and codes driven during traceback that must be ignored.

// File: rtl/align_dir_pkg.sv
package align_dir_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    DIR_DIAG = 2'b00,
    DIR_UP   = 2'b01,
    DIR_LEFT = 2'b10,
    DIR_NONE = 2'b11
  } dir_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;   // place the incoming code in the packing register
    logic flush;     // write the packed word to memory
    logic readReq;   // fetch a word for traceback
  } strobe_t;
endpackage

// File: rtl/align_dir_dp.sv
module align_dir_dp
  import align_dir_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int WORDS  = 15,
  localparam int CPW   = WORD_W / CODE_W,
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int SW    = (CPW > 1) ? $clog2(CPW) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [CODE_W-1:0] wrCode,
  input  logic [AW-1:0]     wrAddr,
  input  logic [SW-1:0]     wrSlot,
  input  logic [AW-1:0]     rdAddr,
  input  logic [SW-1:0]     rdSlot,
  output logic [CODE_W-1:0] rdCode
);
  logic [WORD_W-1:0] packReg;
  logic [WORD_W-1:0] packNext;
  logic [WORD_W-1:0] dirMem [WORDS];
  logic [WORD_W-1:0] rdWordQ;
  logic [SW-1:0]     rdSlotQ;

  always_comb begin
    packNext = packReg;
    packNext[int'(wrSlot) * CODE_W +: CODE_W] = wrCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      packReg <= '0;
    end else if (strobe.capture) begin
      if (strobe.flush) packReg <= '0;
      else              packReg <= packNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture && strobe.flush) dirMem[wrAddr] <= packNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWordQ <= '0;
      rdSlotQ <= '0;
    end else if (strobe.readReq) begin
      rdWordQ <= dirMem[rdAddr];
      rdSlotQ <= rdSlot;
    end
  end

  assign rdCode = rdWordQ[int'(rdSlotQ) * CODE_W +: CODE_W];
endmodule

// File: rtl/align_dir_ctrl.sv
module align_dir_ctrl
  import align_dir_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int WORD_W = 36,
  localparam int CPW   = WORD_W / CODE_W,
  localparam int CELLS = ROWS * COLS,
  localparam int WORDS = (CELLS + CPW - 1) / CPW,
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int SW    = (CPW > 1) ? $clog2(CPW) : 1,
  localparam int CW    = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int RW    = $clog2(ROWS + 1),
  localparam int KW    = $clog2(COLS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirValid,
  input  logic              opReady,
  input  logic [CODE_W-1:0] rdCode,
  output strobe_t           strobe,
  output logic [AW-1:0]     wrAddr,
  output logic [SW-1:0]     wrSlot,
  output logic [AW-1:0]     rdAddr,
  output logic [SW-1:0]     rdSlot,
  output logic              recReady,
  output logic              opValid,
  output logic [CODE_W-1:0] opCode,
  output logic              opLast
);
  typedef enum logic [1:0] {S_REC, S_READ, S_EMIT} state_e;

  state_e        state;
  logic [CW-1:0] cellCnt;
  logic [SW-1:0] slotCnt;
  logic [AW-1:0] wordCnt;
  logic [RW-1:0] rowIdx;
  logic [KW-1:0] colIdx;
  logic [RW-1:0] rowNext;
  logic [KW-1:0] colNext;
  dir_e          effDir;
  logic          lastCell;
  int            cellK;

  assign lastCell = (int'(cellCnt) == CELLS - 1);
  assign recReady = (state == S_REC);

  always_comb begin
    strobe         = '0;
    strobe.capture = (state == S_REC) && dirValid;
    strobe.flush   = strobe.capture && ((int'(slotCnt) == CPW - 1) || lastCell);
    strobe.readReq = (state == S_READ);
  end

  assign wrAddr = wordCnt;
  assign wrSlot = slotCnt;

  // column-major position of the current walk cell
  always_comb begin
    if (rowIdx == '0 || colIdx == '0) cellK = 0;
    else cellK = (int'(colIdx) - 1) * ROWS + int'(rowIdx) - 1;
  end
  assign rdAddr = AW'(cellK / CPW);
  assign rdSlot = SW'(cellK % CPW);

  // boundary forcing and the unused code
  always_comb begin
    if (rowIdx == '0)              effDir = DIR_LEFT;
    else if (colIdx == '0)         effDir = DIR_UP;
    else if (rdCode == DIR_NONE)   effDir = DIR_DIAG;
    else                           effDir = dir_e'(rdCode);
  end

  always_comb begin
    rowNext = (effDir == DIR_LEFT) ? rowIdx : rowIdx - 1'b1;
    colNext = (effDir == DIR_UP)   ? colIdx : colIdx - 1'b1;
  end

  assign opValid = (state == S_EMIT);
  assign opCode  = effDir;
  assign opLast  = opValid && (rowNext == '0) && (colNext == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_REC;
      cellCnt <= '0;
      slotCnt <= '0;
      wordCnt <= '0;
      rowIdx  <= '0;
      colIdx  <= '0;
    end else begin
      case (state)
        S_REC: begin
          if (dirValid) begin
            if (lastCell) begin
              cellCnt <= '0;
              slotCnt <= '0;
              wordCnt <= '0;
              rowIdx  <= RW'(ROWS);
              colIdx  <= KW'(COLS);
              state   <= S_READ;
            end else begin
              cellCnt <= cellCnt + 1'b1;
              if (int'(slotCnt) == CPW - 1) begin
                slotCnt <= '0;
                wordCnt <= wordCnt + 1'b1;
              end else begin
                slotCnt <= slotCnt + 1'b1;
              end
            end
          end
        end
        S_READ: state <= S_EMIT;
        S_EMIT: begin
          if (opReady) begin
            rowIdx <= rowNext;
            colIdx <= colNext;
            state  <= opLast ? S_REC : S_READ;
          end
        end
        default: state <= S_REC;
      endcase
    end
  end
endmodule

// File: rtl/align_dir_trace.sv
module align_dir_trace
  import align_dir_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int WORD_W = 36
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dirValid,
  input  logic [1:0] dirCode,
  output logic       recReady,
  output logic       opValid,
  input  logic       opReady,
  output logic [1:0] opCode,
  output logic       opLast
);
  localparam int CPW   = WORD_W / CODE_W;
  localparam int CELLS = ROWS * COLS;
  localparam int WORDS = (CELLS + CPW - 1) / CPW;
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int SW    = (CPW > 1) ? $clog2(CPW) : 1;

  strobe_t           strobe;
  logic [AW-1:0]     wrAddr;
  logic [SW-1:0]     wrSlot;
  logic [AW-1:0]     rdAddr;
  logic [SW-1:0]     rdSlot;
  logic [CODE_W-1:0] rdCode;

  align_dir_ctrl #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dirValid(dirValid), .opReady(opReady),
    .rdCode(rdCode), .strobe(strobe), .wrAddr(wrAddr), .wrSlot(wrSlot),
    .rdAddr(rdAddr), .rdSlot(rdSlot), .recReady(recReady),
    .opValid(opValid), .opCode(opCode), .opLast(opLast)
  );

  align_dir_dp #(.WORD_W(WORD_W), .WORDS(WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrCode(dirCode),
    .wrAddr(wrAddr), .wrSlot(wrSlot), .rdAddr(rdAddr), .rdSlot(rdSlot),
    .rdCode(rdCode)
  );
endmodule

// File: rtl/align_dir_trace_chk.sv
module align_dir_trace_chk #(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       recReady,
  input logic       opValid,
  input logic       opReady,
  input logic [1:0] opCode,
  input logic       opLast
);
  int opCount;

  always_ff @(posedge clk) begin
    if (!rstN) opCount <= 0;
    else if (opValid && opReady) opCount <= opLast ? 0 : opCount + 1;
  end

  // R8: offered operation holds under back-pressure
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !opReady |=> opValid && $stable(opCode) && $stable(opLast));

  // R11: unused code never offered
  a_r11_no_code3: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> opCode != 2'b11);

  // R9 / R4: recording and emitting never overlap
  a_r9_phase_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(recReady && opValid));

  // R7: last flag only on a valid operation
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    opLast |-> opValid);

  // R10: recording resumes after the final operation
  a_r10_back_to_rec: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opReady && opLast |=> recReady && !opValid);

  // R7: traceback length bounded by ROWS+COLS
  a_r7_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> opCount < ROWS + COLS);
endmodule

bind align_dir_trace align_dir_trace_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rstN(rstN), .recReady(recReady), .opValid(opValid),
  .opReady(opReady), .opCode(opCode), .opLast(opLast)
);

// File: tb/align_dir_trace_bench.sv
module align_dir_trace_bench;
  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int MAXOPS = ROWS + COLS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dirValid = 1'b0;
  logic [1:0] dirCode = 2'b00;
  logic       recReady;
  logic       opValid;
  logic       opReady = 1'b0;
  logic [1:0] opCode;
  logic       opLast;

  int checks = 0;
  int fails = 0;
  int grid [ROWS+1][COLS+1];
  int expOps [MAXOPS];
  int expN;

  always #2.5 clk = ~clk;

  align_dir_trace #(.ROWS(ROWS), .COLS(COLS), .WORD_W(36)) u_align_dir_trace (
    .clk(clk), .rstN(rstN), .dirValid(dirValid), .dirCode(dirCode),
    .recReady(recReady), .opValid(opValid), .opReady(opReady),
    .opCode(opCode), .opLast(opLast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected walk from the requirements (R5, R6, code 11 as diagonal per R2)
  function automatic void buildExpected();
    int i = ROWS;
    int j = COLS;
    int d;
    expN = 0;
    while (i > 0 || j > 0) begin
      if (i == 0) d = 2;
      else if (j == 0) d = 1;
      else d = (grid[i][j] == 3) ? 0 : grid[i][j];
      expOps[expN] = d;
      expN++;
      if (d != 2) i--;
      if (d != 1) j--;
    end
  endfunction

  // kind: 0 random, 1 all diagonal, 2 all up, 3 all left
  task automatic sendGrid(input int kind);
    for (int c = 1; c <= COLS; c++) begin
      for (int r = 1; r <= ROWS; r++) begin
        case (kind)
          1: grid[r][c] = 0;
          2: grid[r][c] = 1;
          3: grid[r][c] = 2;
          default: grid[r][c] = int'($urandom % 4);
        endcase
        @(negedge clk);
        while ($urandom % 5 == 0) begin
          dirValid = 1'b0;
          @(negedge clk);
        end
        dirValid = 1'b1;
        dirCode  = 2'(grid[r][c]);
      end
    end
    @(negedge clk);
    dirValid = 1'b0;
    #1;
    check(recReady == 1'b0, "R4 recReady after last cell", int'(recReady), 0);
  endtask

  task automatic traceGrid(input int readyMode);
    int idx = 0;
    bit done = 0;
    int guard = 0;
    buildExpected();
    while (!done && guard < 4000) begin
      @(negedge clk);
      guard++;
      opReady  = (readyMode == 1) ? 1'b1 : 1'($urandom % 2);
      dirValid = 1'($urandom % 2);   // R9 noise during traceback
      dirCode  = 2'($urandom % 4);
      #1;
      if (opValid && opReady) begin
        check(opCode != 2'b11, "R11 code", int'(opCode), expOps[idx]);
        check(int'(opCode) == expOps[idx], "R5/R6/R9 op", int'(opCode), expOps[idx]);
        check(opLast == (idx == expN - 1), "R7 last", int'(opLast), int'(idx == expN - 1));
        idx++;
        if (opLast || idx >= expN) done = 1;
      end
    end
    check(idx == expN, "R7 op count", idx, expN);
    @(negedge clk);
    dirValid = 1'b0;
    opReady  = 1'b0;
    #1;
    check(recReady == 1'b1 && opValid == 1'b0, "R10 recording resumes", int'(recReady), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(recReady == 1'b1, "R1 recReady after reset", int'(recReady), 1);
    check(opValid == 1'b0, "R1 opValid after reset", int'(opValid), 0);

    // directed corners: R2 R3 R6 packing and boundary forcing
    sendGrid(1); traceGrid(1);
    sendGrid(2); traceGrid(0);
    sendGrid(3); traceGrid(0);
    // random grids including code 11 and partial final word (R2, R3, R8, R10)
    for (int g = 0; g < 6; g++) begin
      sendGrid(0);
      traceGrid(g % 2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule